// File: doc/BRIEF.md
# Bitmask Sparse Operand Pairing Unit

This block pairs the nonzero elements of a pruned weight row with the nonzero elements of an activation vector. Both operands are described by bitmasks of the same width: one bit per original position, set when the element is nonzero and therefore present in its compacted store. After a start strobe the unit captures both masks and ANDs them into a working mask. It then issues one matching position per accepted handshake, always the lowest one left, and clears that bit.

With each position the unit gives two addresses. The weight address is the number of weight-mask bits set below the position. The activation address is the same count taken over the activation mask. A multiply-accumulate lane downstream can therefore read both compacted stores directly. The next position is found by a combinational lowest-one detector and the two addresses by combinational prefix counts, so each issue takes one cycle. No walk through a pointer structure is needed. When the working mask is empty the unit raises a one-cycle done flag and returns to idle.

Top module: `sparse_pair_scan`

## Requirements
- R1: During reset and in the first cycle after reset is released, out_valid and done are low.
- R2: Every issued position has both its weight-mask bit and its activation-mask bit set in the masks captured at start, so a pruned weight never leads to a weight-store read.
- R3: Positions in a window are issued in strictly ascending order. The lowest remaining set bit of the ANDed mask is always issued next.
- R4: out_waddr equals the number of captured weight-mask bits set at indices below out_pos.
- R5: out_aaddr equals the number of captured activation-mask bits set at indices below out_pos, counted independently of the weight mask.
- R6: While out_valid is high and out_ready is low, out_valid, out_pos, out_waddr and out_aaddr keep their values.
- R7: done is high for exactly one cycle, once the last pair has been accepted. out_valid is low in that cycle.
- R8: If the ANDed mask is all zero when start is accepted, done is high in the cycle right after the start cycle and out_valid stays low.
- R9: A start strobe while a window is still being processed (including its done cycle) is ignored. The window in progress continues with its originally captured masks.
- R10: Each set bit of the ANDed mask is issued exactly once per window.
- R11: With out_ready held high, a window with K matching positions gives K consecutive valid cycles, starting in the cycle after start, followed by done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begins a window; both masks are captured in this cycle if idle |
| wmask | input | N | Weight nonzero mask, bit i for position i |
| amask | input | N | Activation nonzero mask, bit i for position i |
| out_ready | input | 1 | Downstream accepts the current triple |
| out_valid | output | 1 | A position/address triple is offered |
| out_pos | output | $clog2(N) | Original position of the matched pair |
| out_waddr | output | $clog2(N) | Address in the compacted weight store |
| out_aaddr | output | $clog2(N) | Address in the compacted activation store |
| done | output | 1 | One-cycle pulse when the window is exhausted |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives while a window is only partly drained, especially in the done cycle, with masks different from the captured ones. The stimulus fires extra starts carrying fresh random masks at random points of each window, under randomly throttled out_ready. This means stalls, late starts and the done cycle all meet. The behavioural model checks that the sequence of triples still follows the first masks. Directed windows cover the full mask, the empty mask and weight/activation masks of very different densities, so the two address counts drift apart.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/sps_lowest_one.sv
module sps_lowest_one #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);
  // isolate the lowest set bit
  assign onehot = vec & (~vec + N'(1));

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/sps_prefix_count.sv
module sps_prefix_count #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [N-1:0]  sel_onehot,
  output logic [IW-1:0] count
);
  logic [N-1:0] below;

  assign below = sel_onehot - N'(1);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      if (below[i] && mask[i]) count = count + IW'(1);
    end
  end
endmodule

// File: rtl/sps_tracker.sv
module sps_tracker
  import sps_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N-1:0] wmask,
  input  logic [N-1:0] amask,
  input  logic         fire,
  input  logic [N-1:0] issued_onehot,
  output logic         busy,
  output logic [N-1:0] work_q,
  output logic [N-1:0] wm_q,
  output logic [N-1:0] am_q
);
  scan_state_e  state_q, state_d;
  logic [N-1:0] work_d;
  logic         cap_en;
  logic         work_en;

  always_comb begin
    state_d = state_q;
    work_d  = work_q;
    cap_en  = 1'b0;
    work_en = 1'b0;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start) begin
          cap_en  = 1'b1;
          work_en = 1'b1;
          work_d  = wmask & amask;
          state_d = SCAN_RUN;
        end
      end
      SCAN_RUN: begin
        if (work_q == '0) begin
          state_d = SCAN_IDLE;
        end else if (fire) begin
          work_en = 1'b1;
          work_d  = work_q & ~issued_onehot;
        end
      end
      default: state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      work_q  <= '0;
    end else begin
      state_q <= state_d;
      if (work_en) work_q <= work_d;
    end
  end

  // mask copies need no reset: only read while busy
  always_ff @(posedge clk) begin
    if (cap_en) begin
      wm_q <= wmask;
      am_q <= amask;
    end
  end

  assign busy = (state_q == SCAN_RUN);
endmodule

// File: rtl/sparse_pair_scan.sv
module sparse_pair_scan #(
  parameter int N = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N-1:0]         wmask,
  input  logic [N-1:0]         amask,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [$clog2(N)-1:0] out_pos,
  output logic [$clog2(N)-1:0] out_waddr,
  output logic [$clog2(N)-1:0] out_aaddr,
  output logic                 done
);
  localparam int IW = $clog2(N);

  logic         busy;
  logic [N-1:0] work_q;
  logic [N-1:0] wm_q;
  logic [N-1:0] am_q;
  logic [N-1:0] low_onehot;
  logic         fire;
  logic         remaining;

  sps_tracker #(.N(N)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .wmask        (wmask),
    .amask        (amask),
    .fire         (fire),
    .issued_onehot(low_onehot),
    .busy         (busy),
    .work_q       (work_q),
    .wm_q         (wm_q),
    .am_q         (am_q)
  );

  sps_lowest_one #(.N(N), .IW(IW)) u_lod (
    .vec   (work_q),
    .onehot(low_onehot),
    .idx   (out_pos)
  );

  sps_prefix_count #(.N(N), .IW(IW)) u_wcnt (
    .mask      (wm_q),
    .sel_onehot(low_onehot),
    .count     (out_waddr)
  );

  sps_prefix_count #(.N(N), .IW(IW)) u_acnt (
    .mask      (am_q),
    .sel_onehot(low_onehot),
    .count     (out_aaddr)
  );

  assign remaining = |work_q;
  assign out_valid = busy && remaining;
  assign done      = busy && !remaining;
  assign fire      = out_valid && out_ready;
endmodule

// File: rtl/sps_checker.sv
module sps_checker #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [N-1:0]  wmask,
  input logic [N-1:0]  amask,
  input logic          out_ready,
  input logic          out_valid,
  input logic [IW-1:0] out_pos,
  input logic [IW-1:0] out_waddr,
  input logic [IW-1:0] out_aaddr,
  input logic          done,
  input logic          busy,
  input logic [N-1:0]  wm_q,
  input logic [N-1:0]  am_q
);
  logic [N-1:0]  below_pos;
  logic [IW-1:0] last_pos;
  logic          have_last;

  assign below_pos = (N'(1) << out_pos) - N'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos  <= '0;
      have_last <= 1'b0;
    end else if (done) begin
      have_last <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_pos  <= out_pos;
      have_last <= 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (!out_valid && !done));

  a_r2_both_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (wm_q[out_pos] && am_q[out_pos]));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && have_last) |-> (out_pos > last_pos));

  a_r4_weight_addr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_waddr == IW'($countones(wm_q & below_pos))));

  a_r5_act_addr: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_aaddr == IW'($countones(am_q & below_pos))));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pos) && $stable(out_waddr) && $stable(out_aaddr)));

  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((wmask & amask) == '0)) |=> done);

  a_r9_masks_kept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(wm_q) && $stable(am_q)));
endmodule

bind sparse_pair_scan sps_checker #(.N(N), .IW(IW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .wmask    (wmask),
  .amask    (amask),
  .out_ready(out_ready),
  .out_valid(out_valid),
  .out_pos  (out_pos),
  .out_waddr(out_waddr),
  .out_aaddr(out_aaddr),
  .done     (done),
  .busy     (busy),
  .wm_q     (wm_q),
  .am_q     (am_q)
);

// File: tb/sparse_pair_scan_bench.sv
module sparse_pair_scan_bench;
  localparam int N  = 32;
  localparam int IW = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [N-1:0]  wmask;
  logic [N-1:0]  amask;
  logic          out_ready;
  logic          out_valid;
  logic [IW-1:0] out_pos;
  logic [IW-1:0] out_waddr;
  logic [IW-1:0] out_aaddr;
  logic          done;

  int n_chk;
  int n_fail;

  sparse_pair_scan #(.N(N)) u_sparse_pair_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .wmask(wmask), .amask(amask),
    .out_ready(out_ready), .out_valid(out_valid), .out_pos(out_pos),
    .out_waddr(out_waddr), .out_aaddr(out_aaddr), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit       m_busy;
  int       qp[$];
  int       qw[$];
  int       qa[$];
  bit [N-1:0] mw;
  bit [N-1:0] ma;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0;
      qp.delete(); qw.delete(); qa.delete();
    end else if (m_busy) begin
      if (qp.size() == 0) m_busy = 1'b0;
      else if (out_ready) begin
        void'(qp.pop_front()); void'(qw.pop_front()); void'(qa.pop_front());
      end
    end else if (start) begin
      int cw;
      int ca;
      cw = 0; ca = 0;
      mw = wmask; ma = amask;
      for (int i = 0; i < N; i++) begin
        if (wmask[i] && amask[i]) begin
          qp.push_back(i); qw.push_back(cw); qa.push_back(ca);
        end
        if (wmask[i]) cw++;
        if (amask[i]) ca++;
      end
      m_busy = 1'b1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit ev;
      ev = m_busy && (qp.size() > 0);
      chk(out_valid == ev, "R10 valid", out_valid, ev);
      chk(done == (m_busy && qp.size() == 0), "R7 done", done, m_busy && qp.size() == 0);
      if (ev && out_valid) begin
        chk(int'(out_pos) == qp[0], "R3 position", out_pos, qp[0]);
        chk(int'(out_waddr) == qw[0], "R4 weight address", out_waddr, qw[0]);
        chk(int'(out_aaddr) == qa[0], "R5 activation address", out_aaddr, qa[0]);
        chk(mw[out_pos] && ma[out_pos], "R2 both bits set", {mw[out_pos], ma[out_pos]}, 3);
      end
    end
  end

  task automatic pulse_start(input logic [N-1:0] w, input logic [N-1:0] a);
    @(negedge clk);
    start = 1'b1; wmask = w; amask = a;
    @(negedge clk);
    start = 1'b0; wmask = $urandom(); amask = $urandom();
  endtask

  task automatic wait_idle();
    while (m_busy) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 5) == 0) begin
        start = 1'b1; wmask = $urandom(); amask = $urandom();   // R9 stray start
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    start = 1'b0; wmask = '0; amask = '0; out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && !done, "R1 reset outputs", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done, "R1 after release", {out_valid, done}, 0);

    // R11: full window, ready high
    out_ready = 1'b1;
    pulse_start('1, '1);
    begin
      int nv;
      nv = 0;
      while (out_valid) begin nv++; @(negedge clk); end
      chk(nv == N, "R11 back-to-back issues", nv, N);
      chk(done == 1'b1, "R11 done after last", done, 1);
    end
    @(negedge clk);

    // R8: empty ANDed mask
    @(negedge clk);
    start = 1'b1; wmask = 32'hAAAA_AAAA; amask = 32'h5555_5555;
    @(negedge clk);
    start = 1'b0;
    chk(done && !out_valid, "R8 empty window done", {done, out_valid}, 2);
    @(negedge clk);
    chk(!done, "R7 single-cycle done", done, 0);

    // R6: stall holds outputs; R5 diverging counts
    out_ready = 1'b0;
    pulse_start(32'hFFFF_0F0F, 32'h0103_0301);
    begin
      logic [IW-1:0] p, w, a;
      p = out_pos; w = out_waddr; a = out_aaddr;
      repeat (4) @(negedge clk);
      chk(out_valid && out_pos == p && out_waddr == w && out_aaddr == a,
          "R6 stall stable", out_pos, p);
    end
    // R9: start during busy, then drain
    start = 1'b1; wmask = '1; amask = '1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // random windows with throttled ready and stray starts
    for (int k = 0; k < 60; k++) begin
      logic [N-1:0] w, a;
      w = $urandom(); a = $urandom();
      if (k % 3 == 1) a = a & $urandom() & $urandom();
      if (k % 7 == 3) w = '0;
      pulse_start(w, a);
      wait_idle();
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    // reset mid-window
    out_ready = 1'b0;
    pulse_start('1, '1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done, "R1 mid-window reset", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !done, "R1 idle after reset", {out_valid, done}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule